// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Alarm

This block keeps wall-clock time in packed BCD: seconds, minutes, hours (24-hour), day of month, month, two-digit year and a weekday counter. It advances once per pulse on a one-second `tick` input, but only while software has set the run bit. The day count follows each month's length, and February gets 29 days in years divisible by four.

A byte-wide register bus gives software access to the time, a set of alarm registers, control, status, interrupt enable and two spare compensation bytes. Software can freeze a coherent copy of the time into shadow registers and then read it byte by byte. A single `irq` output combines two sources. The first is a sticky alarm status. The second is a sticky periodic event chosen from second, minute, hour or day. Both status bits are cleared by writing ones to them.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset the time is 00:00:00, day 01, month 01, year 00, weekday 0. The clock is stopped, control, interrupt enable, alarm and compensation registers are zero, status reads 0x80 and `irq` is low.
- R2: Addresses 0x00-0x06 hold seconds, minutes, hours, day, month, year and weekday. Addresses 0x07-0x0C hold the alarm seconds through alarm year. 0x0D is control, 0x0E is status and 0x0F is interrupt enable. 0x10 and 0x11 are compensation bytes. Any other address reads 0. Read data appears in the cycle after the `rd` strobe and holds until the next read.
- R3: Control bit 0 is the run bit. A `tick` advances the time by one second only while this bit is 1. With the bit at 0, ticks change nothing.
- R4: Seconds and minutes wrap from 59 to 00, hours from 23 to 00, month from 12 to 01 and year from 99 to 00. The weekday advances on every day rollover and wraps from 6 to 0.
- R5: The day wraps to 01 after day 30 in April, June, September and November, and after day 31 in the other months. In February it wraps after day 29 when the year is divisible by 4, and after day 28 otherwise.
- R6: Writing control with bit 6 set copies the live seconds-through-year into shadow registers. While control bit 6 stays 1, reads of 0x00-0x05 return the shadow values. Reads of the weekday at 0x06 always return the live value.
- R7: Status bit 1 reads the run bit. A counting tick sets status bit 2. Bit 3 is set on a minute rollover, bit 4 on an hour rollover and bit 5 on a day rollover. Bits 2-7 clear when 1 is written to them. If an event sets a bit in the same cycle that a write clears it, the set wins. Status bit 0 reads 0.
- R8: Status bit 6 (alarm) is set by a counting tick when the resulting seconds, minutes, hours, day, month and year all equal the alarm registers.
- R9: Status bit 7 is set by reset and cleared only by writing 1 to it.
- R10: In the interrupt enable register, bits [1:0] pick the periodic source: 00 second (status bit 2), 01 minute (bit 3), 10 hour (bit 4), 11 day (bit 5). Bit 2 enables the periodic interrupt and bit 3 enables the alarm interrupt. Bits 7:4 read 0. `irq` = (alarm status AND bit 3) OR (selected status bit AND bit 2).
- R11: A write to any of 0x00-0x06 in the same cycle as a tick stores the written byte. Nothing advances in that cycle and no event is set.
- R12: The compensation bytes and control bits 1-5 and 7 are plain read/write storage. They have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse once per second |
| addr | input | AW (5) | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
Two pairs of functions can land in the same clock cycle. A counting tick can coincide with a write-one-to-clear of the status bit that the tick sets. A tick can also coincide with a bus write to a time register. The bench drives the tick and the bus write in one cycle to provoke each case. It then judges the result from the status readback, the `irq` level and the time readback. These are compared every clock against a behavioural model that applies the rule that the set wins over the clear, and that a time write suppresses the advance.

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          wr,
  input  logic          rd,
  output logic [7:0]    rdata,
  output logic          irq
);
  localparam int NT      = 7;
  localparam int NA      = 6;
  localparam int A_ALRM  = NT;
  localparam int A_CTRL  = A_ALRM + NA;
  localparam int A_STAT  = A_CTRL + 1;
  localparam int A_IEN   = A_STAT + 1;
  localparam int A_COMP  = A_IEN + 1;

  function automatic logic [6:0] to_bin(input logic [7:0] b);
    return 7'({3'b000, b[7:4]} * 7'd10 + {3'b000, b[3:0]});
  endfunction

  function automatic logic [7:0] to_bcd(input logic [6:0] n);
    return {4'(n / 7'd10), 4'(n % 7'd10)};
  endfunction

  logic [7:0] tm   [NT];
  logic [7:0] nt   [NT];
  logic [7:0] al   [NA];
  logic [7:0] sh   [NA];
  logic [7:0] comp [2];
  logic [7:0] ctrl;
  logic [7:2] st;
  logic [3:0] ie;
  logic [7:0] rd_mux;

  logic [6:0] s_i, m_i, h_i, d_i, mo_i, y_i, dmax;
  logic       sw, mw, hw, dw, mow, carry_m, carry_h, carry_d, carry_mo, carry_y;
  logic       time_wr, adv, hit;

  assign s_i  = to_bin(tm[0]);
  assign m_i  = to_bin(tm[1]);
  assign h_i  = to_bin(tm[2]);
  assign d_i  = to_bin(tm[3]);
  assign mo_i = to_bin(tm[4]);
  assign y_i  = to_bin(tm[5]);

  always_comb begin
    unique case (mo_i)
      7'd2:                      dmax = (y_i[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   dmax = 7'd30;
      default:                   dmax = 7'd31;
    endcase
  end

  assign sw  = s_i  >= 7'd59;
  assign mw  = m_i  >= 7'd59;
  assign hw  = h_i  >= 7'd23;
  assign dw  = d_i  >= dmax;
  assign mow = mo_i >= 7'd12;

  assign carry_m  = sw;
  assign carry_h  = carry_m & mw;
  assign carry_d  = carry_h & hw;
  assign carry_mo = carry_d & dw;
  assign carry_y  = carry_mo & mow;

  assign nt[0] = sw ? 8'h00 : to_bcd(s_i + 7'd1);
  assign nt[1] = !carry_m ? tm[1] : (mw ? 8'h00 : to_bcd(m_i + 7'd1));
  assign nt[2] = !carry_h ? tm[2] : (hw ? 8'h00 : to_bcd(h_i + 7'd1));
  assign nt[3] = !carry_d ? tm[3] : (dw ? 8'h01 : to_bcd(d_i + 7'd1));
  assign nt[4] = !carry_mo ? tm[4] : (mow ? 8'h01 : to_bcd(mo_i + 7'd1));
  assign nt[5] = !carry_y ? tm[5] : ((y_i >= 7'd99) ? 8'h00 : to_bcd(y_i + 7'd1));
  assign nt[6] = !carry_d ? tm[6] : ((tm[6] >= 8'h06) ? 8'h00 : tm[6] + 8'h01);

  assign time_wr = wr && (addr < AW'(NT));
  assign adv     = tick && ctrl[0] && !time_wr;

  always_comb begin
    hit = 1'b1;
    for (int i = 0; i < NA; i++) if (nt[i] != al[i]) hit = 1'b0;
  end

  always_comb begin
    rd_mux = 8'h00;
    for (int i = 0; i < NA; i++) if (addr == AW'(i)) rd_mux = ctrl[6] ? sh[i] : tm[i];
    if (addr == AW'(NT - 1)) rd_mux = tm[NT-1];
    for (int i = 0; i < NA; i++) if (addr == AW'(A_ALRM + i)) rd_mux = al[i];
    if (addr == AW'(A_CTRL)) rd_mux = ctrl;
    if (addr == AW'(A_STAT)) rd_mux = {st, ctrl[0], 1'b0};
    if (addr == AW'(A_IEN))  rd_mux = {4'h0, ie};
    for (int i = 0; i < 2; i++) if (addr == AW'(A_COMP + i)) rd_mux = comp[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) tm[i] <= (i == 3 || i == 4) ? 8'h01 : 8'h00;
      for (int i = 0; i < NA; i++) begin
        al[i] <= 8'h00;
        sh[i] <= 8'h00;
      end
      comp[0] <= 8'h00;
      comp[1] <= 8'h00;
      ctrl    <= 8'h00;
      st      <= 6'b100000;
      ie      <= 4'h0;
      rdata   <= 8'h00;
    end else begin
      if (rd) rdata <= rd_mux;
      for (int i = 0; i < NT; i++) begin
        if (wr && addr == AW'(i)) tm[i] <= wdata;
        else if (adv)             tm[i] <= nt[i];
      end
      for (int i = 0; i < NA; i++) if (wr && addr == AW'(A_ALRM + i)) al[i] <= wdata;
      if (wr && addr == AW'(A_CTRL)) begin
        ctrl <= wdata;
        if (wdata[6]) for (int i = 0; i < NA; i++) sh[i] <= tm[i];
      end
      if (wr && addr == AW'(A_IEN)) ie <= wdata[3:0];
      for (int i = 0; i < 2; i++) if (wr && addr == AW'(A_COMP + i)) comp[i] <= wdata;
      st <= (st & ~((wr && addr == AW'(A_STAT)) ? wdata[7:2] : 6'b0))
          | {1'b0, adv & hit, adv & carry_d, adv & carry_h, adv & carry_m, adv};
    end
  end

  logic [3:0] evt;
  assign evt = st[5:2];
  assign irq = (st[6] & ie[3]) | (ie[2] & evt[ie[1:0]]);

endmodule

module rtc_assertions #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic [7:0]    wdata,
  input logic          irq,
  input logic          run,
  input logic [7:2]    st,
  input logic [3:0]    ie,
  input logic [7:0]    sec
);
  a_r10_alarm_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (st[6] && ie[3]) |-> irq);

  a_r3_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr && addr == AW'(0))) |=> $stable(sec));

  a_r9_powerup_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st[7] && !(wr && addr == AW'(14) && wdata[7])) |=> st[7]);

  a_r8_alarm_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[6]) |-> $past(tick && run));
endmodule

bind bcd_calendar_rtc rtc_assertions #(.AW(AW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tick  (tick),
  .wr    (wr),
  .addr  (addr),
  .wdata (wdata),
  .irq   (irq),
  .run   (ctrl[0]),
  .st    (st),
  .ie    (ie),
  .sec   (tm[0])
);

// File: tb/tb_bcd_calendar_rtc.sv
module tb_bcd_calendar_rtc;
  logic       clk = 0, rst_n = 0, tick = 0, wr = 0, rd = 0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  bcd_calendar_rtc dut (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wdata(wdata),
                        .wr(wr), .rd(rd), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  int vectors = 0, errors = 0;
  string req = "R1";
  bit done = 0;

  int m_t[7], m_al[6], m_sh[6], m_comp[2];
  int m_ctrl, m_st, m_ie, e_rdata;

  function automatic int bcd(int n); return ((n / 10) << 4) | (n % 10); endfunction
  function automatic int unbcd(int b); return ((b >> 4) & 15) * 10 + (b & 15); endfunction

  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int mread(int a);
    if (a <= 5) return bcd((m_ctrl & 64) ? m_sh[a] : m_t[a]);
    if (a == 6) return bcd(m_t[6]);
    if (a >= 7 && a <= 12) return bcd(m_al[a-7]);
    if (a == 13) return m_ctrl;
    if (a == 14) return (m_st & 'hFC) | ((m_ctrl & 1) << 1);
    if (a == 15) return m_ie;
    if (a == 16 || a == 17) return m_comp[a-16];
    return 0;
  endfunction

  always @(posedge clk) begin
    int n[7];
    int set, clr;
    bit adv;
    if (!rst_n) begin
      m_t = '{0, 0, 0, 1, 1, 0, 0};
      foreach (m_al[i]) begin m_al[i] = 0; m_sh[i] = 0; end
      m_comp = '{0, 0};
      m_ctrl = 0; m_st = 'h80; m_ie = 0; e_rdata = 0;
    end else begin
      if (rd) e_rdata = mread(int'(addr));
      adv = tick && (m_ctrl & 1) && !(wr && addr <= 6);
      n = m_t;
      set = 0;
      if (adv) begin
        set = 4;
        n[0]++;
        if (n[0] == 60) begin
          n[0] = 0; set |= 8; n[1]++;
          if (n[1] == 60) begin
            n[1] = 0; set |= 16; n[2]++;
            if (n[2] == 24) begin
              n[2] = 0; set |= 32; n[6] = (n[6] + 1) % 7; n[3]++;
              if (n[3] > mdays(n[4], n[5])) begin
                n[3] = 1; n[4]++;
                if (n[4] == 13) begin n[4] = 1; n[5] = (n[5] + 1) % 100; end
              end
            end
          end
        end
        if (n[0] == m_al[0] && n[1] == m_al[1] && n[2] == m_al[2] &&
            n[3] == m_al[3] && n[4] == m_al[4] && n[5] == m_al[5]) set |= 64;
      end
      if (wr && addr == 13 && wdata[6]) for (int i = 0; i < 6; i++) m_sh[i] = m_t[i];
      clr = (wr && addr == 14) ? (int'(wdata) & 'hFC) : 0;
      m_st = (m_st & ~clr) | set;
      if (adv) m_t = n;
      if (wr) begin
        if (addr <= 6) m_t[addr] = unbcd(int'(wdata));
        else if (addr <= 12) m_al[addr-7] = unbcd(int'(wdata));
        else if (addr == 13) m_ctrl = int'(wdata);
        else if (addr == 15) m_ie = int'(wdata) & 15;
        else if (addr == 16 || addr == 17) m_comp[addr-16] = int'(wdata);
      end
    end
  end

  function automatic bit exp_irq();
    return (((m_st >> 6) & 1) && ((m_ie >> 3) & 1)) ||
           (((m_ie >> 2) & 1) && ((m_st >> (2 + (m_ie & 3))) & 1));
  endfunction

  task automatic compare();
    vectors++;
    if (irq !== exp_irq()) begin
      errors++;
      $display("FAIL %s irq actual=%0b expected=%0b at %0t", req, irq, exp_irq(), $time);
    end
    vectors++;
    if (rdata !== e_rdata[7:0]) begin
      errors++;
      $display("FAIL %s rdata actual=%02h expected=%02h at %0t", req, rdata, e_rdata[7:0], $time);
    end
  endtask

  task automatic step(bit w, int a, int d, bit r, bit t);
    @(negedge clk);
    compare();
    wr = w; addr = a[4:0]; wdata = d[7:0]; rd = r; tick = t;
  endtask

  task automatic wreg(int a, int d); step(1, a, d, 0, 0); endtask
  task automatic rreg(int a);        step(0, a, 0, 1, 0); endtask
  task automatic tk();               step(0, 0, 0, 0, 1); endtask
  task automatic idle();             step(0, 0, 0, 0, 0); endtask

  task automatic dump();
    for (int a = 0; a < 18; a++) rreg(a);
    rreg('h12);
    rreg('h1F);
    idle();
  endtask

  task automatic settime(int s, int m, int h, int d, int mo, int y, int wd);
    wreg(0, bcd(s)); wreg(1, bcd(m)); wreg(2, bcd(h)); wreg(3, bcd(d));
    wreg(4, bcd(mo)); wreg(5, bcd(y)); wreg(6, bcd(wd));
  endtask

  task automatic tick_dump();
    tk(); idle(); dump();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    req = "R1"; dump();
    // R2 register map, alarm storage, unmapped addresses
    req = "R2";
    for (int i = 0; i < 6; i++) wreg(7 + i, bcd(11 + i));
    dump();
    // R12 storage bits have no effect; stopped clock ignores ticks (R3)
    req = "R12"; wreg(13, 'hBE); wreg(16, 'hA5); wreg(17, 'h5A);
    tk(); tk(); tk(); dump();
    req = "R3"; settime(58, 59, 23, 28, 2, 24, 6);
    wreg(13, 'h3F); wreg(15, 'h04);
    tick_dump();
    wreg(14, 'h04); idle();
    // R4 and R5 rollovers
    req = "R5"; tick_dump(); wreg(14, 'hFC);
    settime(59, 59, 23, 29, 2, 24, 0); tick_dump(); wreg(14, 'hFC);
    settime(59, 59, 23, 28, 2, 23, 3); tick_dump(); wreg(14, 'hFC);
    settime(59, 59, 23, 30, 4, 23, 1); tick_dump(); wreg(14, 'hFC);
    req = "R4"; settime(59, 59, 23, 31, 12, 99, 6); tick_dump(); wreg(14, 'hFC);
    settime(59, 59, 23, 31, 1, 7, 2); tick_dump(); wreg(14, 'hFC);
    // R10 periodic interval selection
    req = "R10"; wreg(15, 'h05); settime(58, 59, 10, 5, 5, 5, 0);
    tk(); idle(); rreg(14); tk(); idle(); rreg(14); wreg(14, 'h08); idle();
    wreg(15, 'h06); settime(59, 59, 10, 5, 5, 5, 0); tk(); idle(); rreg(14);
    wreg(15, 'h07); idle(); wreg(15, 'h04); idle(); wreg(15, 'hF3); rreg(15);
    wreg(14, 'hFC);
    // R7 tick sets a bit in the same cycle software clears it
    req = "R7"; wreg(15, 'h04); step(1, 14, 'h04, 0, 1); idle(); rreg(14);
    wreg(14, 'hFC); tk(); idle(); rreg(14); wreg(14, 'hFC); idle();
    // R11 time write coinciding with a tick
    req = "R11"; step(1, 0, bcd(30), 0, 1); idle(); rreg(0); rreg(14);
    // R8 alarm match
    req = "R8"; wreg(14, 'hFC); wreg(15, 'h08);
    settime(10, 0, 12, 15, 6, 30, 2);
    wreg(7, bcd(12)); wreg(8, 0); wreg(9, bcd(12)); wreg(10, bcd(15)); wreg(11, bcd(6)); wreg(12, bcd(30));
    tk(); idle(); tk(); idle(); rreg(14); tk(); idle();
    step(1, 14, 'h40, 0, 1); idle(); rreg(14);
    wreg(13, 'h00); wreg(0, bcd(11)); tk(); idle(); rreg(14); rreg(0);
    // R6 snapshot
    req = "R6"; wreg(13, 'h01); tk(); wreg(13, 'h41); tk(); idle(); tk(); dump();
    wreg(13, 'h01); dump();
    // R9 power-up flag
    req = "R9"; wreg(14, 'h7C); rreg(14); wreg(14, 'h80); rreg(14); idle(); idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule